// File: doc/BRIEF.md
# SMBus Word-Register Target

This block is a target-only two-wire management bus endpoint that exposes a small bank of 16-bit words to a host controller. It watches the clock and data lines, which arrive already synchronized to the system clock, and recognizes bus START and STOP conditions. It answers a single fixed 7-bit address. It supports exactly two transactions. The first is a word write, made of an address byte with the write flag, a command byte, then the low and high data bytes. The second is a word read, made of an address byte with the write flag, a command byte, a repeated START, an address byte with the read flag, and then two bytes returned by the target.

The command byte selects the word. Four words are writable control settings: an option word, a charge-current word, a charge-voltage word and an input-current word. Their values appear on dedicated outputs for the rest of the chip. Two further commands return fixed identification words and cannot be written. The data line is open-drain: the block only ever pulls it low through `sda_oe`, and it never drives the clock. All bus activity needs two enables, supply-good and adapter-present. If either one is low, the block releases the line and stays silent.

Top module: `smbus_word_target`

## Requirements
- R1: After synchronous reset, `sda_oe` is 0 and all four writable words read as 0x0000.
- R2: The target acknowledges an address byte whose upper seven bits equal 0x09, with bit 0 as the read flag (1 = read). Any other address gets no acknowledge, and the rest of that transaction is ignored until the next START.
- R3: A START is the data line falling while the clock is high. A STOP is the data line rising while the clock is high. A START at any point restarts byte framing. A STOP at any point returns the target to idle.
- R4: A word write acknowledges each of its four bytes. Data bytes arrive most significant bit first, low byte before high byte. The addressed word takes its new value only after the high byte has been acknowledged. The commands are 0x12 (options), 0x14 (charge current), 0x15 (charge voltage) and 0x3F (input current).
- R5: A word read returns the addressed word low byte first, each byte most significant bit first. The target changes `sda_oe` only while the clock is low.
- R6: Command 0xFE reads the manufacturer identification word (parameter `MFR_ID`). Command 0xFF reads the device identification word (parameter `DEV_ID`). Writes to either are acknowledged and have no effect.
- R7: An unsupported command byte is still acknowledged. A write to it changes no word, and a read of it returns 0x0000.
- R8: While `en_supply` or `en_adapter` is low, the target gives no acknowledge, keeps `sda_oe` at 0 and changes no word.
- R9: If the host does not acknowledge the low byte of a read, the target releases the data line for the rest of the transaction. After the high byte, the target releases the line and goes idle.
- R10: A word write cut short by a STOP or a repeated START before the high byte is acknowledged leaves every word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_supply | input | 1 | Supply above undervoltage lockout |
| en_adapter | input | 1 | Adapter-detect above threshold |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| opt_word | output | 16 | Option word (command 0x12) |
| chg_cur_word | output | 16 | Charge-current word (command 0x14) |
| chg_volt_word | output | 16 | Charge-voltage word (command 0x15) |
| in_cur_word | output | 16 | Input-current word (command 0x3F) |

## Verification
The bench targets the points where framing can slip:
- A write cut off by a STOP after its low byte: a target that commits early would corrupt the charge-voltage word.
- A START inside a byte, and a repeated START inside a write: a target that does not clear its bit counter would lose framing and then acknowledge the wrong bit slot.
- A read whose low byte the host refuses: a target that carries on would drive the high byte onto a line the host believes is free.
- Addresses one apart from the real one, writes to the identification and unsupported commands, and each enable dropped in turn: a target that gets these wrong would acknowledge, or would alter a setting, when it should stay silent.

// File: rtl/smbus_word_pkg.sv
package smbus_word_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int NUM_WREG = 4;
  localparam int SLOT_W   = $clog2(NUM_WREG);

  localparam logic [BYTE_W-1:0] CMD_OPTIONS = 8'h12;
  localparam logic [BYTE_W-1:0] CMD_CHG_CUR = 8'h14;
  localparam logic [BYTE_W-1:0] CMD_CHG_VLT = 8'h15;
  localparam logic [BYTE_W-1:0] CMD_IN_CUR  = 8'h3F;
  localparam logic [BYTE_W-1:0] CMD_MFR_ID  = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_DEV_ID  = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WLO, ST_WHI, ST_RLO, ST_RHI
  } xfer_state_e;
endpackage

// File: rtl/smbus_bus_events.sv
module smbus_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges while the clock stays high are bus conditions, not data
  assign ev_start = scl_q & scl_i & sda_q & ~sda_i;
  assign ev_stop  = scl_q & scl_i & ~sda_q & sda_i;
  assign ev_rise  = ~scl_q & scl_i;
  assign ev_fall  = scl_q & ~scl_i;
endmodule

// File: rtl/smbus_word_regs.sv
module smbus_word_regs
  import smbus_word_pkg::*;
#(
  parameter logic [WORD_W-1:0] MFR_ID = 16'h5A17,
  parameter logic [WORD_W-1:0] DEV_ID = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] opt_word,
  output logic [WORD_W-1:0] chg_cur_word,
  output logic [WORD_W-1:0] chg_volt_word,
  output logic [WORD_W-1:0] in_cur_word
);
  logic [WORD_W-1:0] bank [NUM_WREG];
  logic              hit;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    hit  = 1'b1;
    slot = '0;
    case (cmd)
      CMD_OPTIONS: slot = SLOT_W'(0);
      CMD_CHG_CUR: slot = SLOT_W'(1);
      CMD_CHG_VLT: slot = SLOT_W'(2);
      CMD_IN_CUR:  slot = SLOT_W'(3);
      default:     hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WREG; i++) bank[i] <= '0;
    end else if (wr_en && hit) begin
      bank[slot] <= wdata;
    end
  end

  always_comb begin
    if (cmd == CMD_MFR_ID)      rdata = MFR_ID;
    else if (cmd == CMD_DEV_ID) rdata = DEV_ID;
    else if (hit)               rdata = bank[slot];
    else                        rdata = '0;
  end

  assign opt_word      = bank[0];
  assign chg_cur_word  = bank[1];
  assign chg_volt_word = bank[2];
  assign in_cur_word   = bank[3];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({opt_word, chg_cur_word, chg_volt_word, in_cur_word})); // R4
  AST_UNSUPPORTED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable({opt_word, chg_cur_word, chg_volt_word, in_cur_word})); // R7
endmodule

// File: rtl/smbus_word_target.sv
module smbus_word_target
  import smbus_word_pkg::*;
#(
  parameter logic [6:0]        SLAVE_ADDR = 7'h09,
  parameter logic [WORD_W-1:0] MFR_ID     = 16'h5A17,
  parameter logic [WORD_W-1:0] DEV_ID     = 16'h00C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_supply,
  input  logic              en_adapter,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [WORD_W-1:0] opt_word,
  output logic [WORD_W-1:0] chg_cur_word,
  output logic [WORD_W-1:0] chg_volt_word,
  output logic [WORD_W-1:0] in_cur_word
);
  localparam int CNT_W     = $clog2(BYTE_W + 2);
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]     LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]     ACK_DONE = CNT_W'(BYTE_W + 1);
  localparam logic [BIT_IDX_W-1:0] TOP_IDX  = BIT_IDX_W'(BYTE_W - 1);

  logic bus_en;
  logic ev_start, ev_stop, ev_rise, ev_fall;
  xfer_state_e state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, lo_byte, cmd_q, tx_byte;
  logic [WORD_W-1:0] tx_word, rd_word;
  logic rw_q, mst_ack, wr_en, receiving, sending;
  logic [BIT_IDX_W-1:0] tx_idx;

  assign bus_en    = en_supply & en_adapter;
  assign receiving = state inside {ST_ADDR, ST_CMD, ST_WLO, ST_WHI};
  assign sending   = state inside {ST_RLO, ST_RHI};
  assign tx_byte   = (state == ST_RHI) ? tx_word[WORD_W-1:BYTE_W] : tx_word[BYTE_W-1:0];
  assign tx_idx    = TOP_IDX - bitcnt[BIT_IDX_W-1:0];
  // commit only once the high-byte acknowledge clock has completed
  assign wr_en     = bus_en && !ev_start && !ev_stop && ev_fall &&
                     state == ST_WHI && bitcnt == ACK_DONE;

  smbus_bus_events u_events (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  smbus_word_regs #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(cmd_q),
    .wdata({shreg, lo_byte}), .rdata(rd_word),
    .opt_word(opt_word), .chg_cur_word(chg_cur_word),
    .chg_volt_word(chg_volt_word), .in_cur_word(in_cur_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sda_oe  <= 1'b0;
      shreg   <= '0;
      lo_byte <= '0;
      cmd_q   <= '0;
      tx_word <= '0;
      rw_q    <= 1'b0;
      mst_ack <= 1'b0;
    end else if (!bus_en || ev_stop) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (ev_start) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (ev_rise) begin
        bitcnt <= bitcnt + 1'b1;
        if (receiving && bitcnt < LAST_BIT) shreg <= {shreg[BYTE_W-2:0], sda_i};
        if (sending && bitcnt == LAST_BIT)  mst_ack <= ~sda_i;
      end else if (ev_fall) begin
        if (bitcnt == LAST_BIT) begin
          if (sending) begin
            sda_oe <= 1'b0;                 // host owns the acknowledge slot
          end else begin
            sda_oe <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (shreg[BYTE_W-1:1] != SLAVE_ADDR) begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end else begin
                  rw_q <= shreg[0];
                end
              end
              ST_CMD:  cmd_q   <= shreg;
              ST_WLO:  lo_byte <= shreg;
              default: ;
            endcase
          end
        end else if (bitcnt == ACK_DONE) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_ADDR: begin
              if (rw_q) begin
                state   <= ST_RLO;
                tx_word <= rd_word;
                sda_oe  <= ~rd_word[BYTE_W-1];
              end else begin
                state <= ST_CMD;
              end
            end
            ST_CMD: state <= ST_WLO;
            ST_WLO: state <= ST_WHI;
            ST_RLO: begin
              if (mst_ack) begin
                state  <= ST_RHI;
                sda_oe <= ~tx_word[WORD_W-1];
              end else begin
                state <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end else if (sending && bitcnt != '0) begin
          sda_oe <= ~tx_byte[tx_idx];
        end
      end
    end
  end

  AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !(en_supply && en_adapter) |=> !sda_oe); // R8
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_i)); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R2
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= ACK_DONE); // R3
endmodule

// File: tb/smbus_word_target_test.sv
module smbus_word_target_test;
  localparam int Q = 4;
  localparam logic [6:0]  ADDR = 7'h09;
  localparam logic [15:0] MFR  = 16'h5A17;
  localparam logic [15:0] DEV  = 16'h00C3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, en_supply = 1'b1, en_adapter = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [15:0] opt_word, chg_cur_word, chg_volt_word, in_cur_word;

  assign sda_line = sda_m & ~sda_oe;

  smbus_word_target uut (
    .clk(clk), .rst(rst), .en_supply(en_supply), .en_adapter(en_adapter),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .opt_word(opt_word), .chg_cur_word(chg_cur_word),
    .chg_volt_word(chg_volt_word), .in_cur_word(in_cur_word)
  );

  int n_chk = 0, n_fail = 0;
  int exp_val[$];
  string exp_tag[$];
  int obs_val[$];

  // monitor: pairs each observed bus item with the expected item in order
  always @(negedge clk) begin
    int a, e;
    string t;
    while (obs_val.size() > 0 && exp_val.size() > 0) begin
      a = obs_val.pop_front();
      e = exp_val.pop_front();
      t = exp_tag.pop_front();
      n_chk++;
      if (a != e) begin
        n_fail++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q / 2);
    b = sda_line; tick(Q - Q / 2); scl = 1'b0;
  endtask

  // ack observed as 1 when the line is pulled low in the ninth slot
  task automatic send_byte(logic [7:0] v, int exp_ack, string tag);
    logic b;
    exp_val.push_back(exp_ack); exp_tag.push_back(tag);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    obs_val.push_back(b ? 0 : 1);
  endtask

  task automatic recv_byte(int exp, logic host_ack, string tag);
    logic b;
    logic [7:0] v;
    exp_val.push_back(exp); exp_tag.push_back(tag);
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    obs_val.push_back(int'(v));
    put_bit(~host_ack);
  endtask

  task automatic write_word(logic [6:0] a, logic [7:0] c, logic [15:0] d, int ack, string tag);
    bus_start();
    send_byte({a, 1'b0}, ack, tag);
    send_byte(c, ack, tag);
    send_byte(d[7:0], ack, tag);
    send_byte(d[15:8], ack, tag);
    bus_stop();
    tick(2);
  endtask

  task automatic read_word(logic [7:0] c, logic [15:0] exp, string tag);
    bus_start();
    send_byte({ADDR, 1'b0}, 1, tag);
    send_byte(c, 1, tag);
    bus_start();
    send_byte({ADDR, 1'b1}, 1, tag);
    recv_byte(int'(exp[7:0]), 1'b1, tag);
    recv_byte(int'(exp[15:8]), 1'b0, tag);
    tick(1);
    chk({tag, " released after high byte (R9)"}, int'(sda_oe), 0);
    bus_stop();
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(4);
    // R1 reset state
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 words", int'(opt_word | chg_cur_word | chg_volt_word | in_cur_word), 0);

    // R4 word writes, low byte first
    write_word(ADDR, 8'h12, 16'hA55A, 1, "R4 ack");
    chk("R4 opt_word", int'(opt_word), 16'hA55A);
    write_word(ADDR, 8'h14, 16'h1280, 1, "R4 ack");
    write_word(ADDR, 8'h15, 16'h3070, 1, "R4 ack");
    write_word(ADDR, 8'h3F, 16'h0C01, 1, "R4 ack");
    chk("R4 chg_cur_word", int'(chg_cur_word), 16'h1280);
    chk("R4 chg_volt_word", int'(chg_volt_word), 16'h3070);
    chk("R4 in_cur_word", int'(in_cur_word), 16'h0C01);

    // R5 reads
    read_word(8'h12, 16'hA55A, "R5 read opt");
    read_word(8'h3F, 16'h0C01, "R5 read in_cur");

    // R6 identification words, read-only
    read_word(8'hFE, MFR, "R6 mfr id");
    read_word(8'hFF, DEV, "R6 dev id");
    write_word(ADDR, 8'hFF, 16'h1234, 1, "R6 write ack");
    read_word(8'hFF, DEV, "R6 dev id after write");

    // R7 unsupported command
    write_word(ADDR, 8'h20, 16'hBEEF, 1, "R7 ack");
    chk("R7 words unchanged", int'(opt_word ^ chg_cur_word ^ chg_volt_word ^ in_cur_word),
        int'(16'hA55A ^ 16'h1280 ^ 16'h3070 ^ 16'h0C01));
    read_word(8'h20, 16'h0000, "R7 read zero");

    // R2 foreign addresses
    write_word(7'h08, 8'h12, 16'h0F0F, 0, "R2 addr 0x08");
    write_word(7'h0A, 8'h12, 16'h0F0F, 0, "R2 addr 0x0A");
    write_word(7'h49, 8'h12, 16'h0F0F, 0, "R2 addr 0x49");
    chk("R2 opt_word unchanged", int'(opt_word), 16'hA55A);

    // R8 enable gating
    en_adapter = 1'b0;
    write_word(ADDR, 8'h14, 16'hFFFF, 0, "R8 adapter off");
    en_adapter = 1'b1; en_supply = 1'b0;
    write_word(ADDR, 8'h14, 16'hFFFF, 0, "R8 supply off");
    en_supply = 1'b1;
    chk("R8 chg_cur_word unchanged", int'(chg_cur_word), 16'h1280);

    // R10 write cut short by STOP after low byte
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R10 ack");
    send_byte(8'h15, 1, "R10 ack");
    send_byte(8'h99, 1, "R10 ack");
    bus_stop();
    tick(2);
    chk("R10 chg_volt_word after stop", int'(chg_volt_word), 16'h3070);

    // R3 repeated START mid-write restarts framing; R10 old word untouched
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R3 ack");
    send_byte(8'h15, 1, "R3 ack");
    send_byte(8'h77, 1, "R3 ack");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R3 ack after restart");
    send_byte(8'h14, 1, "R3 ack after restart");
    send_byte(8'h34, 1, "R3 ack after restart");
    send_byte(8'h12, 1, "R3 ack after restart");
    bus_stop();
    tick(2);
    chk("R3 chg_cur_word", int'(chg_cur_word), 16'h1234);
    chk("R10 chg_volt_word after restart", int'(chg_volt_word), 16'h3070);

    // R3 START in the middle of an address byte
    bus_start();
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R3 mid-byte start");
    send_byte(8'h12, 1, "R3 mid-byte start");
    send_byte(8'hCD, 1, "R3 mid-byte start");
    send_byte(8'hAB, 1, "R3 mid-byte start");
    bus_stop();
    tick(2);
    chk("R3 opt_word", int'(opt_word), 16'hABCD);

    // R9 host refuses the low byte: line stays released
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R9 ack");
    send_byte(8'h12, 1, "R9 ack");
    bus_start();
    send_byte({ADDR, 1'b1}, 1, "R9 ack");
    recv_byte(16'hCD, 1'b0, "R9 low byte");
    recv_byte(16'hFF, 1'b0, "R9 released high byte");
    bus_stop();
    tick(2);
    read_word(8'h15, 16'h3070, "R5 read after refused read");

    tick(4);
    if (exp_val.size() != obs_val.size()) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard residue actual=%0d expected=%0d", obs_val.size(), exp_val.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule